// File: doc/BRIEF.md
# Channel-Status Word Capture with Interrupt Flags

This block sits behind a digital-audio line decoder and receives one strobe per decoded frame, carrying that frame's channel-status bit, its validity bit and a marker for the first frame of a status block. From the marked frame onward it shifts the first `CS_BITS` channel-status bits into a private shadow register. The first bit received lands in the most significant position. When the last of those bits arrives, the whole word moves at once into a readable holding register. A processor can therefore read the holding register at any moment and never sees a half-built word.

Two interrupt flags report events. The change flag is set each time the holding register is loaded. The invalid-sample flag is set for every frame whose validity bit is 1. Software clears either flag by writing a 1 to its bit through a clear strobe. An optional variant also clears the change flag on a read strobe. A per-flag enable mask gates a single combined interrupt line.

Top module: `cscap_capture`

## Requirements
- R1: While reset is asserted and after it is released, `cs_word` is 0, both bits of `irq_flags` are 0 and `irq` is 0.
- R2: Channel-status bit k of a block, counted from the frame flagged by `blk_start` as k = 0, appears at `cs_word[CS_BITS-1-k]`. Bit 0 therefore lands in the MSB and bit `CS_BITS-1` in the LSB.
- R3: `cs_word` keeps its previous value while a block is being assembled. It changes only on the clock edge that samples the `CS_BITS`-th frame strobe of the block.
- R4: `irq_flags[0]` (change) is set on the edge that loads a new word into `cs_word`.
- R5: `irq_flags[1]` (invalid sample) is set on the edge of every frame strobe with `vbit` = 1. A frame with `vbit` = 0 does not set it.
- R6: A cycle with `clr_wr` = 1 clears each flag whose `clr_data` bit is 1, and leaves every flag whose `clr_data` bit is 0 unchanged.
- R7: When a flag's set event and its clear fall in the same cycle, the flag is set afterwards.
- R8: A `blk_start` frame that arrives before `CS_BITS` bits have been collected discards the partial word and restarts assembly with its own bit as bit 0.
- R9: Frame strobes after the `CS_BITS`-th bit and before the next `blk_start` do not change `cs_word` and do not set the change flag.
- R10: `irq` is 1 exactly when some flag is set and its bit in `irq_en` is 1, in the same cycle as the flags.
- R11: With the default `RD_CLEARS` = 1, a `rd_stb` cycle clears the change flag. It leaves the invalid-sample flag and `cs_word` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_vld | input | 1 | One-cycle strobe per decoded frame |
| blk_start | input | 1 | Marks the frame as bit 0 of a status block |
| cbit | input | 1 | Channel-status bit of the frame |
| vbit | input | 1 | Validity bit of the frame, 1 = sample invalid |
| rd_stb | input | 1 | Processor read of `cs_word` |
| clr_wr | input | 1 | Write strobe of the write-one-to-clear flag register |
| clr_data | input | 2 | Clear mask: bit 0 change flag, bit 1 invalid flag |
| irq_en | input | 2 | Per-flag interrupt enable, same bit order |
| cs_word | output | CS_BITS | Readable channel-status word |
| irq_flags | output | 2 | Bit 0 change flag, bit 1 invalid-sample flag |
| irq | output | 1 | Combined enabled interrupt |

## Verification
Every registered result, namely the loaded word, the change flag and the invalid-sample flag, is due one clock edge after the cycle that presents the frame, clear or read strobe. `irq` follows the flags combinationally in that same cycle. The bench drives each stimulus on a falling edge and compares all outputs on the next falling edge, after exactly one rising edge. A bench model updates its expected values for that one edge, so every check lands in the cycle the result is due.

// File: rtl/cscap_pkg.sv
package cscap_pkg;
   localparam int FLAG_CHG  = 0;
   localparam int FLAG_INV  = 1;
   localparam int NUM_FLAGS = 2;
   typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/cscap_assemble.sv
// Shadow assembly of the channel-status word, first bit ends in the MSB.
module cscap_assemble #(
   parameter int CS_BITS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_vld,
   input  logic               blk_start,
   input  logic               cbit,
   output logic               load,
   output logic [CS_BITS-1:0] full_word
);
   localparam int CNT_W = $clog2(CS_BITS + 1);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CS_BITS - 1);

   logic [CS_BITS-1:0] shadow;
   logic [CNT_W-1:0]   cnt;
   logic               active;

   always_comb begin
      full_word = {shadow[CS_BITS-2:0], cbit};
      load      = frame_vld && active && !blk_start && (cnt == LAST_IDX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         cnt    <= '0;
         active <= 1'b0;
      end else if (frame_vld) begin
         if (blk_start) begin
            shadow <= {{(CS_BITS-1){1'b0}}, cbit};
            cnt    <= CNT_W'(1);
            active <= 1'b1;
         end else if (active) begin
            shadow <= full_word;
            cnt    <= cnt + CNT_W'(1);
            if (cnt == LAST_IDX) active <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cscap_flag.sv
// One sticky interrupt flag; a set in the same cycle as a clear wins.
module cscap_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set | (q & ~clr);
   end
endmodule

// File: rtl/cscap_capture.sv
module cscap_capture
   import cscap_pkg::*;
#(
   parameter int CS_BITS   = 32,
   parameter bit RD_CLEARS = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_vld,
   input  logic                 blk_start,
   input  logic                 cbit,
   input  logic                 vbit,
   input  logic                 rd_stb,
   input  logic                 clr_wr,
   input  logic [NUM_FLAGS-1:0] clr_data,
   input  logic [NUM_FLAGS-1:0] irq_en,
   output logic [CS_BITS-1:0]   cs_word,
   output logic [NUM_FLAGS-1:0] irq_flags,
   output logic                 irq
);
   if (CS_BITS < 2 || CS_BITS > 64) begin : g_bad_width
      $error("cscap_capture: CS_BITS must lie in 2..64");
   end

   logic               load;
   logic [CS_BITS-1:0] full_word;
   flag_vec_t          set_v;
   flag_vec_t          clr_v;

   cscap_assemble #(.CS_BITS(CS_BITS)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_vld (frame_vld),
      .blk_start (blk_start),
      .cbit      (cbit),
      .load      (load),
      .full_word (full_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cs_word <= '0;
      else if (load) cs_word <= full_word;
   end

   always_comb begin
      set_v           = '0;
      set_v[FLAG_CHG] = load;
      set_v[FLAG_INV] = frame_vld & vbit;
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      if (i == FLAG_CHG && RD_CLEARS) begin : g_rdclr
         assign clr_v[i] = (clr_wr & clr_data[i]) | rd_stb;
      end else begin : g_w1c
         assign clr_v[i] = clr_wr & clr_data[i];
      end
      cscap_flag u_flag (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (set_v[i]),
         .clr   (clr_v[i]),
         .q     (irq_flags[i])
      );
   end

   assign irq = |(irq_flags & irq_en);
endmodule

// File: rtl/cscap_capture_chk.sv
module cscap_capture_chk #(
   parameter int CS_BITS = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               frame_vld,
   input logic               vbit,
   input logic               clr_wr,
   input logic [1:0]         clr_data,
   input logic [1:0]         irq_en,
   input logic [CS_BITS-1:0] cs_word,
   input logic [1:0]         irq_flags,
   input logic               irq
);
   p_reset_r1: assert property (@(posedge clk) !rst_n |=> (cs_word == '0 && irq_flags == 2'b00));

   p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(frame_vld) |-> $stable(cs_word));

   p_chg_on_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cs_word) |-> irq_flags[0]);

   p_inv_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_flags[1]) |-> $past(frame_vld && vbit));

   p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_wr && clr_data[1] && !(frame_vld && vbit)) |-> !irq_flags[1]);

   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frame_vld && vbit) |-> irq_flags[1]);

   p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((irq_flags & irq_en) != 2'b00));
endmodule

bind cscap_capture cscap_capture_chk #(.CS_BITS(CS_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_vld (frame_vld),
   .vbit      (vbit),
   .clr_wr    (clr_wr),
   .clr_data  (clr_data),
   .irq_en    (irq_en),
   .cs_word   (cs_word),
   .irq_flags (irq_flags),
   .irq       (irq)
);

// File: tb/tb_cscap_capture.sv
module tb_cscap_capture;
   localparam int CLK_PERIOD = 10;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         frame_vld = 1'b0, blk_start = 1'b0, cbit = 1'b0, vbit = 1'b0;
   logic         rd_stb = 1'b0, clr_wr = 1'b0;
   logic [1:0]   clr_data = 2'b00, irq_en = 2'b00;
   logic [W-1:0] cs_word;
   logic [1:0]   irq_flags;
   logic         irq;

   int n_chk = 0, n_fail = 0, cycles = 0;
   bit done = 0;

   // reference model state
   logic [W-1:0] m_shadow = '0, m_word = '0;
   int           m_cnt = 0;
   bit           m_act = 0;
   logic [1:0]   m_flags = 2'b00;

   cscap_capture #(.CS_BITS(W)) dut (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic exp_irq(input logic [1:0] f, input logic [1:0] en);
      return |(f & en);
   endfunction

   task automatic compare(input string tag);
      chk(cs_word == m_word, tag, "cs_word", 64'(cs_word), 64'(m_word));
      chk(irq_flags == m_flags, tag, "irq_flags", 64'(irq_flags), 64'(m_flags));
      chk(irq == exp_irq(m_flags, irq_en), tag, "irq", 64'(irq), 64'(exp_irq(m_flags, irq_en)));
   endtask

   // one cycle: drive at falling edge, model one rising edge, compare at next falling edge
   task automatic step(input bit fv, input bit st, input bit c, input bit v,
                       input bit cw, input logic [1:0] cd, input bit rd, input string tag);
      logic       ld;
      logic [1:0] setv, clrv;
      frame_vld = fv; blk_start = st; cbit = c; vbit = v;
      clr_wr = cw; clr_data = cd; rd_stb = rd;
      ld = 1'b0;
      if (fv) begin
         if (st) begin
            m_shadow = {{(W-1){1'b0}}, c}; m_cnt = 1; m_act = 1;
         end else if (m_act) begin
            m_shadow = {m_shadow[W-2:0], c}; m_cnt++;
            if (m_cnt == W) begin ld = 1'b1; m_word = m_shadow; m_act = 0; end
         end
      end
      setv = {fv & v, ld};
      clrv = cw ? cd : 2'b00;
      clrv[0] = clrv[0] | rd;
      m_flags = setv | (m_flags & ~clrv);
      @(posedge clk);
      @(negedge clk);
      frame_vld = 0; blk_start = 0; rd_stb = 0; clr_wr = 0; clr_data = 2'b00;
      compare(tag);
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 2'b00, 0, tag);
   endtask

   // frames first..last of a block, bit k taken from pat[W-1-k] when k < W
   task automatic frames(input logic [W-1:0] pat, input int first, input int last, input string tag);
      for (int k = first; k <= last; k++) begin
         bit c = (k < W) ? pat[W-1-k] : 1'($urandom);
         step(1, k == 0, c, 0, 0, 2'b00, 0, tag);
      end
   endtask

   initial begin : watchdog
      while (!done) begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
         end
      end
   end

   initial begin : stim
      logic [W-1:0] pat;
      void'($urandom(32'h5eed_c0de));
      // R1: reset state, during and after reset
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");
      irq_en = 2'b11;

      // R2 bit order, R3 hold during assembly, R4 change flag
      pat = 32'hA5C3_0F71;
      frames(pat, 0, 15, "R3");
      chk(cs_word == '0, "R3", "word mid-block", 64'(cs_word), 64'h0);
      frames(pat, 16, 31, "R2");
      chk(cs_word == pat, "R2", "first bit left", 64'(cs_word), 64'(pat));
      chk(irq_flags[0] == 1'b1, "R4", "change flag", 64'(irq_flags[0]), 64'h1);
      // R6: writing zeros leaves flags, ones clear
      step(0, 0, 0, 0, 1, 2'b00, 0, "R6");
      chk(irq_flags[0] == 1'b1, "R6", "zero write no effect", 64'(irq_flags[0]), 64'h1);
      step(0, 0, 0, 0, 1, 2'b01, 0, "R6");
      chk(irq_flags[0] == 1'b0, "R6", "one write clears", 64'(irq_flags[0]), 64'h0);
      // R9: trailing frames ignored
      frames(pat, 32, 60, "R9");
      chk(cs_word == pat && irq_flags[0] == 1'b0, "R9", "trailing frames", 64'(cs_word), 64'(pat));

      // R8: early restart discards partial word
      pat = 32'h1234_FEDC;
      frames(32'hFFFF_FFFF, 0, 9, "R8");
      frames(pat, 0, 30, "R8");
      chk(cs_word == 32'hA5C3_0F71, "R3", "old word kept", 64'(cs_word), 64'hA5C3_0F71);
      // R7: change set collides with clear on the loading frame
      step(1, 0, pat[0], 0, 1, 2'b01, 0, "R7");
      chk(cs_word == pat, "R8", "restarted word", 64'(cs_word), 64'(pat));
      chk(irq_flags[0] == 1'b1, "R7", "set beats clear", 64'(irq_flags[0]), 64'h1);

      // R11: read strobe clears change only
      step(1, 0, 0, 1, 0, 2'b00, 0, "R5");
      chk(irq_flags[1] == 1'b1, "R5", "invalid frame sets", 64'(irq_flags[1]), 64'h1);
      step(0, 0, 0, 0, 0, 2'b00, 1, "R11");
      chk(irq_flags == 2'b10 && cs_word == pat, "R11", "read clears change", 64'(irq_flags), 64'h2);
      // R7 on invalid flag
      step(1, 0, 0, 1, 1, 2'b10, 0, "R7");
      chk(irq_flags[1] == 1'b1, "R7", "invalid set beats clear", 64'(irq_flags[1]), 64'h1);
      step(0, 0, 0, 0, 1, 2'b10, 0, "R6");
      step(1, 0, 0, 0, 0, 2'b00, 0, "R5");
      chk(irq_flags[1] == 1'b0, "R5", "valid frame no set", 64'(irq_flags[1]), 64'h0);

      // R10: enable mask
      step(1, 0, 0, 1, 0, 2'b00, 0, "R10");
      irq_en = 2'b01; #1;
      chk(irq == 1'b0, "R10", "masked flag", 64'(irq), 64'h0);
      irq_en = 2'b10; #1;
      chk(irq == 1'b1, "R10", "enabled flag", 64'(irq), 64'h1);
      idle("R10");

      // constrained random blocks
      for (int b = 0; b < 40; b++) begin
         irq_en = 2'($urandom);
         for (int k = 0; k < 192; k++) begin
            bit fv = ($urandom % 4) != 0;
            bit st = (k == 0) || (($urandom % 60) == 0);
            step(fv, fv && st, 1'($urandom), ($urandom % 10) == 0,
                 ($urandom % 8) == 0, 2'($urandom), ($urandom % 16) == 0, "R2/R4/R5/R6/R8/R9/R10/R11");
         end
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule